// File: doc/BRIEF.md
# Banked Memory Decoder with Paging Latch

This block sits between an 8-bit processor with a 16-bit address bus and its memories. Every address is split into one of three device selects: RAM, EEPROM or I/O. Each select comes with the wider physical address that the chosen device needs. A 512K RAM is reached as sixteen 32K pages. An 8-bit paging register in I/O space chooses the page shown in the lower half of the map. The RAM in the upper window stays on one fixed page. A 32K EEPROM is reached as eight 4K banks through the top 4K of the map. The bank is also chosen by the paging register.

The paging register also drives a status LED, which is active low. Software loads the register with any bus cycle to its address. The register is written on both read and write cycles, so a read copies whatever value is on the data bus at that moment. The selects and addresses depend only on the address and the current register contents. A new register value takes effect on the cycle after the clock edge that loads it.

Top module: `banked_mem_decoder`

## Requirements
- R1: Exactly one select is active for every address: `ram_cs` for 0000-DFFF, `io_cs` for E000-EFFF, `rom_cs` for F000-FFFF. The vector area FFF0-FFFF is part of the `rom_cs` range. The selects do not depend on `cpu_valid`, `cpu_rnw` or the register contents.
- R2: For addresses 0000-7FFF, `ram_addr` equals {register bits 3:0, address bits 14:0}.
- R3: For addresses 8000-DFFF, `ram_addr` equals {4'b0001, address bits 14:0}, whatever the register holds. Page value 1 therefore mirrors the upper RAM into the lower window.
- R4: For addresses F000-FFFF, `rom_addr` equals {register bits 6:4, address bits 11:0}. This also applies to the vector area.
- R5: `led_n` always equals register bit 7. A value of 0 means the LED is lit.
- R6: After reset the register holds 00. This gives RAM page 0, EEPROM bank 0 and `led_n` = 0.
- R7: A cycle with `cpu_valid` high and address EF00 loads `cpu_data` into the register at the clock edge, whatever the value of `cpu_rnw`. The outputs reflect the new value after that edge.
- R8: The register keeps its value on cycles where `cpu_valid` is low, and on valid cycles to any other address, including other I/O addresses.
- R9: `ram_addr` is all zeros while `ram_cs` is low, and `rom_addr` is all zeros while `rom_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | Data bus value seen by the paging register |
| cpu_rnw | input | 1 | Read (1) / write (0); has no effect on the register load |
| cpu_valid | input | 1 | Bus cycle valid strobe |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 1 | EEPROM select |
| io_cs | output | 1 | I/O select |
| ram_addr | output | 19 | Physical RAM address |
| rom_addr | output | 15 | Physical EEPROM address |
| led_n | output | 1 | Status LED drive, active low |

## Verification
The selects and both physical addresses are combinational. They are due in the same cycle the address is applied. The bench drives each input on a falling edge and samples one nanosecond later, with no rising edge in between. A register load takes effect one edge after the strobe: the bench holds the strobe across exactly one rising edge, drops it at the next falling edge, and only then reads the new page, bank and LED through the outputs. The hold cases work the same way. The bench applies the ignored cycle, then reads the register back through `ram_addr`, `rom_addr` and `led_n` after the following edge.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_W     = 4;
    localparam int BANK_W     = 3;
    localparam int WIN_W      = 15;
    localparam int ROMWIN_W   = 12;
    localparam int RAM_ADDR_W = PAGE_W + WIN_W;
    localparam int ROM_ADDR_W = BANK_W + ROMWIN_W;

    localparam logic [ADDR_W-1:0] HI_BASE  = 16'h8000;
    localparam logic [ADDR_W-1:0] IO_BASE  = 16'hE000;
    localparam logic [ADDR_W-1:0] ROM_BASE = 16'hF000;
    localparam logic [PAGE_W-1:0] FIXED_PAGE = 4'd1;

    typedef enum logic [1:0] {
        RG_RAM_LO = 2'd0,
        RG_RAM_HI = 2'd1,
        RG_IO     = 2'd2,
        RG_ROM    = 2'd3
    } region_e;

    typedef struct packed {
        logic              led_n;
        logic [BANK_W-1:0] rom_bank;
        logic [PAGE_W-1:0] ram_page;
    } page_reg_t;
endpackage

// File: rtl/bmd_region_dec.sv
module bmd_region_dec
    import bmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr < HI_BASE)       region = RG_RAM_LO;
        else if (addr < IO_BASE)  region = RG_RAM_HI;
        else if (addr < ROM_BASE) region = RG_IO;
        else                      region = RG_ROM;
    end
endmodule

// File: rtl/bmd_page_latch.sv
module bmd_page_latch
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output page_reg_t         page_q
);
    page_reg_t page_d;

    always_comb begin
        page_d = page_q;
        if (load) page_d = page_reg_t'(din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) page_q <= '0;
        else        page_q <= page_d;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page_q));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (page_q == $past(din)));
endmodule

// File: rtl/bmd_addr_map.sv
module bmd_addr_map
    import bmd_pkg::*;
(
    input  region_e               region,
    input  logic [WIN_W-1:0]      offs,
    input  page_reg_t             page,
    output logic                  ram_cs,
    output logic                  rom_cs,
    output logic                  io_cs,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic [ROM_ADDR_W-1:0] rom_addr
);
    always_comb begin
        ram_cs   = 1'b0;
        rom_cs   = 1'b0;
        io_cs    = 1'b0;
        ram_addr = '0;
        rom_addr = '0;
        unique case (region)
            RG_RAM_LO: begin
                ram_cs   = 1'b1;
                ram_addr = {page.ram_page, offs};
            end
            RG_RAM_HI: begin
                ram_cs   = 1'b1;
                ram_addr = {FIXED_PAGE, offs};
            end
            RG_IO: io_cs = 1'b1;
            RG_ROM: begin
                rom_cs   = 1'b1;
                rom_addr = {page.rom_bank, offs[ROMWIN_W-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/banked_mem_decoder.sv
module banked_mem_decoder
    import bmd_pkg::*;
#(
    parameter logic [15:0] LATCH_ADDR = 16'hEF00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_rnw,
    input  logic        cpu_valid,
    output logic        ram_cs,
    output logic        rom_cs,
    output logic        io_cs,
    output logic [18:0] ram_addr,
    output logic [14:0] rom_addr,
    output logic        led_n
);
    region_e   region;
    page_reg_t page_q;
    logic      latch_load;
    logic      rnw_unused;

    // the load ignores the transfer direction on purpose
    assign rnw_unused = cpu_rnw;
    assign latch_load = cpu_valid && (cpu_addr == LATCH_ADDR);

    bmd_region_dec u_region (
        .addr   (cpu_addr),
        .region (region)
    );

    bmd_page_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (latch_load),
        .din    (cpu_data),
        .page_q (page_q)
    );

    bmd_addr_map u_map (
        .region   (region),
        .offs     (cpu_addr[WIN_W-1:0]),
        .page     (page_q),
        .ram_cs   (ram_cs),
        .rom_cs   (rom_cs),
        .io_cs    (io_cs),
        .ram_addr (ram_addr),
        .rom_addr (rom_addr)
    );

    assign led_n = page_q.led_n;

    p_one_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_cs, rom_cs, io_cs}) == 1);
    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'h8000 && cpu_addr < 16'hE000) |->
            (ram_cs && ram_addr[18:15] == 4'd1));
    p_vector_rom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hFFF0) |-> (rom_cs && rom_addr[11:0] == cpu_addr[11:0]));
    p_idle_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs |-> ram_addr == '0) and (!rom_cs |-> rom_addr == '0));
endmodule

// File: tb/banked_mem_decoder_tb_top.sv
module banked_mem_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rnw = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        ram_cs, rom_cs, io_cs, led_n;
    logic [18:0] ram_addr;
    logic [14:0] rom_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    banked_mem_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rnw(cpu_rnw), .cpu_valid(cpu_valid), .ram_cs(ram_cs),
        .rom_cs(rom_cs), .io_cs(io_cs), .ram_addr(ram_addr),
        .rom_addr(rom_addr), .led_n(led_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply an address combinationally and let it settle away from the edge
    task automatic look(logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
    endtask

    task automatic bus(logic [15:0] a, logic [7:0] d, logic rnw, logic v);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rnw = rnw; cpu_valid = v;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_data = 8'h5A;
    endtask

    // read the register state back through the outputs
    task automatic expect_reg(string req, logic [7:0] r);
        look(16'h1234);
        chk(req, ram_addr, {r[3:0], 15'h1234});
        chk(req, led_n, r[7]);
        look(16'hF567);
        chk(req, rom_addr, {r[6:4], 12'h567});
    endtask

    task automatic t_reset;
        expect_reg("R6", 8'h00);
        chk("R6 led lit", led_n, 1'b0);
    endtask

    task automatic t_decode;
        logic [15:0] pts [8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hDFFF,
                                 16'hE000, 16'hEFFF, 16'hF000, 16'hFFFF};
        logic [2:0]  ex  [8] = '{3'b100, 3'b100, 3'b100, 3'b100,
                                 3'b001, 3'b001, 3'b010, 3'b010};
        for (int i = 0; i < 8; i++) begin
            look(pts[i]);
            chk("R1 selects", {ram_cs, rom_cs, io_cs}, ex[i]);
            if (!ram_cs) chk("R9 ram idle", ram_addr, 0);
            if (!rom_cs) chk("R9 rom idle", rom_addr, 0);
        end
        cpu_valid = 1'b1; cpu_rnw = 1'b0;
        look(16'hE123);
        chk("R1 strobe-independent", {ram_cs, rom_cs, io_cs}, 3'b001);
        cpu_valid = 1'b0; cpu_rnw = 1'b1;
    endtask

    task automatic t_low_window;
        bus(16'hEF00, 8'h8B, 1'b0, 1'b1);
        look(16'h0000);
        chk("R2 page B base", ram_addr, {4'hB, 15'h0000});
        look(16'h7FFF);
        chk("R2 page B top", ram_addr, {4'hB, 15'h7FFF});
        chk("R5 led off", led_n, 1'b1);
        look(16'hE800);
        chk("R1 selects latch-independent", {ram_cs, rom_cs, io_cs}, 3'b001);
    endtask

    task automatic t_upper_fixed;
        look(16'h9ABC);
        chk("R3 fixed page", ram_addr, {4'h1, 15'h1ABC});
        bus(16'hEF00, 8'h01, 1'b0, 1'b1);
        look(16'h1ABC);
        chk("R3 mirror low", ram_addr, {4'h1, 15'h1ABC});
        look(16'h9ABC);
        chk("R3 mirror high", ram_addr, {4'h1, 15'h1ABC});
    endtask

    task automatic t_rom_bank;
        bus(16'hEF00, 8'h70, 1'b0, 1'b1);
        look(16'hF000);
        chk("R4 bank 7", rom_addr, {3'd7, 12'h000});
        look(16'hFFFE);
        chk("R4 vector", rom_addr, {3'd7, 12'hFFE});
        chk("R5 led on", led_n, 1'b0);
        look(16'h4000);
        chk("R9 rom idle in ram", rom_addr, 0);
    endtask

    task automatic t_read_load;
        bus(16'hEF00, 8'hA6, 1'b1, 1'b1);
        expect_reg("R7 read load", 8'hA6);
        // the strobe must see exactly one edge before the value appears
        @(negedge clk);
        cpu_addr = 16'hEF00; cpu_data = 8'h13; cpu_valid = 1'b1;
        #1;
        cpu_addr = 16'h2000; #0.5;
        chk("R7 not before edge", ram_addr, {4'h6, 15'h2000});
        cpu_addr = 16'hEF00;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_data = 8'h5A;
        expect_reg("R7 write load", 8'h13);
    endtask

    task automatic t_no_load;
        bus(16'hEF00, 8'hFF, 1'b0, 1'b0);
        expect_reg("R8 invalid", 8'h13);
        bus(16'hEF01, 8'hFF, 1'b0, 1'b1);
        expect_reg("R8 other io", 8'h13);
        bus(16'h6F00, 8'hFF, 1'b0, 1'b1);
        expect_reg("R8 ram addr", 8'h13);
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_low_window();
        t_upper_fixed();
        t_rom_bank();
        t_read_load();
        t_no_load();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule